// File: doc/BRIEF.md
# Debug Trigger Address Match Unit

This block holds a small bank of address triggers that a hart uses for both breakpoints and watchpoints. Software reaches the bank through a register-style port. A selector picks one trigger. Two data registers then act on that trigger: one holds its control word, the other its compare address. A fourth register holds the global machine-mode trigger enable together with a saved copy of it.

In every cycle each trigger compares the instruction fetch address, the load address and the store address against its compare address. A trigger compares only the access kinds it has enabled. The match is either exact or a naturally aligned power-of-two (NAPOT) range. A hit also depends on the current privilege level. Any qualified hit raises a breakpoint-exception request in the same cycle. At the next clock edge every trigger that hit sets a sticky hit flag. Software can read the flag back and clear it by writing the control word.

The global enable is a small state machine over the pair {saved copy, live enable}. The states are GE_IDLE (both clear), GE_LIVE (live only), GE_PARKED (saved only) and GE_BOTH (both set). A trap into machine mode moves the state: GE_LIVE→GE_PARKED, GE_BOTH→GE_PARKED, GE_PARKED→GE_IDLE, and GE_IDLE stays. A return from machine mode moves it: GE_PARKED→GE_BOTH, GE_LIVE→GE_IDLE, and GE_IDLE and GE_BOTH stay. A register write loads any state directly.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset the selector, every control word, every compare address and both enable bits read 0, and no request is raised.
- R2: Register index 0 is the selector. Writing a value of 4 or more stores 3, the last trigger. Indices 1 (control word) and 2 (compare address) act only on the selected trigger.
- R3: The control word keeps only bits 0 (load), 1 (store), 2 (execute), 3 (user), 6 (machine), 7 (match type) and 20 (hit). Every other bit reads 0. Writing 0 disables the trigger.
- R4: With match type 0, the compare address must equal the access address on all 32 bits.
- R5: With match type 1, the bits above the lowest zero bit of the compare address must equal the same bits of the access address. A compare address of all ones matches every address.
- R6: A fetch is compared only when execute is enabled, a load only when load is enabled, and a store only when store is enabled. Each access counts only while its valid input is high.
- R7: In user mode a trigger needs its user bit. In machine mode it needs its machine bit and the global enable.
- R8: The hit flag is set at the clock edge after a cycle in which that trigger raised the request. It stays set until software writes that trigger's control word.
- R9: When several triggers hit in one cycle, one request line is raised and each matching trigger records its own hit.
- R10: A trap copies the live enable into the saved copy and clears the live enable. A return restores the live enable from the saved copy. A trap wins over a return, and both win over a register write.
- R11: Register index 3 holds the live enable at bit 3 and the saved copy at bit 7. All other bits read 0.
- R12: The request is combinational in the access cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register index: 0 selector, 1 control word, 2 compare address, 3 enable register |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for csr_addr (combinational) |
| priv_m | input | 1 | 1 = machine mode, 0 = user mode |
| trap_enter | input | 1 | Trap into machine mode taken this cycle |
| trap_return | input | 1 | Return from machine mode this cycle |
| fetch_vld | input | 1 | Instruction fetch valid |
| fetch_addr | input | 32 | Instruction fetch address |
| load_vld | input | 1 | Load valid |
| load_addr | input | 32 | Load address |
| store_vld | input | 1 | Store valid |
| store_addr | input | 32 | Store address |
| bkpt_req | output | 1 | Breakpoint-exception request |

## Verification
The bench builds the unit with the default four triggers and a 32-bit address. Four triggers are enough to check the selector clamp at the last index. They also allow two triggers to hit together while a third stays idle. The full 32-bit width lets the bench test the exact compare on the top address bit and the all-ones NAPOT pattern that covers the whole address space.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
    // register indices on the access port
    localparam logic [1:0] RI_SEL  = 2'd0;
    localparam logic [1:0] RI_CTL  = 2'd1;
    localparam logic [1:0] RI_ADR  = 2'd2;
    localparam logic [1:0] RI_GEN  = 2'd3;

    // control word bit positions
    localparam int CB_LD  = 0;
    localparam int CB_ST  = 1;
    localparam int CB_EX  = 2;
    localparam int CB_U   = 3;
    localparam int CB_M   = 6;
    localparam int CB_RNG = 7;
    localparam int CB_HIT = 20;

    // enable register bit positions
    localparam int GB_LIVE  = 3;
    localparam int GB_SAVED = 7;

    // global enable states, encoded {saved, live}
    typedef enum logic [1:0] {
        GE_IDLE   = 2'b00,
        GE_LIVE   = 2'b01,
        GE_PARKED = 2'b10,
        GE_BOTH   = 2'b11
    } ge_state_t;
endpackage

// File: rtl/dtu_gate.sv
module dtu_gate
    import dtu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_gen,
    input  logic [XLEN-1:0] wdata,
    input  logic            trap_enter,
    input  logic            trap_return,
    output logic            live_en,
    output logic            saved_en
);
    ge_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (trap_enter) begin
            unique case (state_q)
                GE_IDLE:   state_d = GE_IDLE;
                GE_LIVE:   state_d = GE_PARKED;
                GE_PARKED: state_d = GE_IDLE;
                GE_BOTH:   state_d = GE_PARKED;
                default:   state_d = GE_IDLE;
            endcase
        end else if (trap_return) begin
            unique case (state_q)
                GE_IDLE:   state_d = GE_IDLE;
                GE_LIVE:   state_d = GE_IDLE;
                GE_PARKED: state_d = GE_BOTH;
                GE_BOTH:   state_d = GE_BOTH;
                default:   state_d = GE_IDLE;
            endcase
        end else if (wr_gen) begin
            state_d = ge_state_t'({wdata[GB_SAVED], wdata[GB_LIVE]});
        end
    end

    always_comb begin
        live_en  = state_q[0];
        saved_en = state_q[1];
    end

    // R10 checks
    a_r10_trap_clears: assert property (@(posedge clk) disable iff (!rst_n)
        trap_enter |=> !live_en);
    a_r10_trap_saves: assert property (@(posedge clk) disable iff (!rst_n)
        trap_enter |=> saved_en == $past(live_en));
    a_r10_ret_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_return && !trap_enter) |=> live_en == $past(saved_en));
endmodule

// File: rtl/dtu_match.sv
module dtu_match
    import dtu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] ctl,
    input  logic [XLEN-1:0] cmp_addr,
    input  logic            priv_m,
    input  logic            live_en,
    input  logic            fetch_vld,
    input  logic [XLEN-1:0] fetch_addr,
    input  logic            load_vld,
    input  logic [XLEN-1:0] load_addr,
    input  logic            store_vld,
    input  logic [XLEN-1:0] store_addr,
    output logic            fire
);
    logic [XLEN-1:0] tail_ones, care;
    logic            mode_ok, ex_hit, ld_hit, st_hit;

    always_comb begin
        // trailing ones of the compare address, then also ignore the lowest zero
        tail_ones = cmp_addr & ~(cmp_addr + XLEN'(1));
        care      = ctl[CB_RNG] ? ~((tail_ones << 1) | XLEN'(1)) : '1;
        mode_ok   = priv_m ? (ctl[CB_M] & live_en) : ctl[CB_U];
        ex_hit    = ctl[CB_EX] & fetch_vld & (((fetch_addr ^ cmp_addr) & care) == '0);
        ld_hit    = ctl[CB_LD] & load_vld  & (((load_addr  ^ cmp_addr) & care) == '0);
        st_hit    = ctl[CB_ST] & store_vld & (((store_addr ^ cmp_addr) & care) == '0);
        fire      = mode_ok & (ex_hit | ld_hit | st_hit);
    end
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
    import dtu_pkg::*;
#(
    parameter int NTRIG = 4,
    parameter int XLEN  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_we,
    input  logic [1:0]      csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    input  logic            priv_m,
    input  logic            trap_enter,
    input  logic            trap_return,
    input  logic            fetch_vld,
    input  logic [XLEN-1:0] fetch_addr,
    input  logic            load_vld,
    input  logic [XLEN-1:0] load_addr,
    input  logic            store_vld,
    input  logic [XLEN-1:0] store_addr,
    output logic            bkpt_req
);
    localparam int SELW = (NTRIG > 1) ? $clog2(NTRIG) : 1;
    localparam logic [XLEN-1:0] CTL_MASK =
        XLEN'((1 << CB_LD) | (1 << CB_ST) | (1 << CB_EX) | (1 << CB_U) |
              (1 << CB_M) | (1 << CB_RNG) | (1 << CB_HIT));

    logic [SELW-1:0] sel_q;
    logic [XLEN-1:0] ctl_q [NTRIG];
    logic [XLEN-1:0] adr_q [NTRIG];
    logic [NTRIG-1:0] fire;
    logic live_en, saved_en;
    logic wr_sel, wr_ctl, wr_adr, wr_gen;

    always_comb begin
        wr_sel = csr_we && csr_addr == RI_SEL;
        wr_ctl = csr_we && csr_addr == RI_CTL;
        wr_adr = csr_we && csr_addr == RI_ADR;
        wr_gen = csr_we && csr_addr == RI_GEN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          sel_q <= '0;
        else if (wr_sel) begin
            if (csr_wdata >= XLEN'(NTRIG)) sel_q <= SELW'(NTRIG - 1);
            else                           sel_q <= SELW'(csr_wdata);
        end
    end

    dtu_gate #(.XLEN(XLEN)) u_gate (
        .clk(clk), .rst_n(rst_n), .wr_gen(wr_gen), .wdata(csr_wdata),
        .trap_enter(trap_enter), .trap_return(trap_return),
        .live_en(live_en), .saved_en(saved_en)
    );

    for (genvar i = 0; i < NTRIG; i++) begin : g_trig
        logic own;
        assign own = (sel_q == SELW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctl_q[i] <= '0;
                adr_q[i] <= '0;
            end else begin
                if (wr_ctl && own)   ctl_q[i] <= csr_wdata & CTL_MASK;
                else if (fire[i])    ctl_q[i][CB_HIT] <= 1'b1;
                if (wr_adr && own)   adr_q[i] <= csr_wdata;
            end
        end

        dtu_match #(.XLEN(XLEN)) u_match (
            .ctl(ctl_q[i]), .cmp_addr(adr_q[i]), .priv_m(priv_m), .live_en(live_en),
            .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
            .load_vld(load_vld), .load_addr(load_addr),
            .store_vld(store_vld), .store_addr(store_addr),
            .fire(fire[i])
        );

        // R8: hit recorded after a fire, and held until its own control write
        a_r8_hit_set: assert property (@(posedge clk) disable iff (!rst_n)
            (fire[i] && !(wr_ctl && own)) |=> ctl_q[i][CB_HIT]);
        a_r8_hit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_q[i][CB_HIT] && !(wr_ctl && own)) |=> ctl_q[i][CB_HIT]);
    end

    assign bkpt_req = |fire;

    always_comb begin
        unique case (csr_addr)
            RI_SEL:  csr_rdata = {{(XLEN-SELW){1'b0}}, sel_q};
            RI_CTL:  csr_rdata = ctl_q[sel_q];
            RI_ADR:  csr_rdata = adr_q[sel_q];
            RI_GEN:  csr_rdata = XLEN'((32'(saved_en) << GB_SAVED) | (32'(live_en) << GB_LIVE));
            default: csr_rdata = '0;
        endcase
    end

    // R7: a request in machine mode needs the live enable
    a_r7_mgate: assert property (@(posedge clk) disable iff (!rst_n)
        (bkpt_req && priv_m) |-> live_en);
endmodule

// File: tb/dbg_trig_unit_test.sv
module dbg_trig_unit_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        csr_we = 0;
    logic [1:0]  csr_addr = 0;
    logic [31:0] csr_wdata = 0;
    logic [31:0] csr_rdata;
    logic        priv_m = 1;
    logic        trap_enter = 0, trap_return = 0;
    logic        fetch_vld = 0, load_vld = 0, store_vld = 0;
    logic [31:0] fetch_addr = 0, load_addr = 0, store_addr = 0;
    logic        bkpt_req;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dbg_trig_unit uut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .priv_m(priv_m),
        .trap_enter(trap_enter), .trap_return(trap_return),
        .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
        .load_vld(load_vld), .load_addr(load_addr),
        .store_vld(store_vld), .store_addr(store_addr), .bkpt_req(bkpt_req)
    );

    localparam logic [31:0] C_L = 32'h1, C_S = 32'h2, C_X = 32'h4, C_U = 32'h8,
                            C_M = 32'h40, C_R = 32'h80, C_H = 32'h0010_0000;

    typedef struct packed {
        logic [31:0] ctl;
        logic [31:0] cmp;
        logic [1:0]  kind;   // 0 fetch, 1 load, 2 store
        logic        pm;
        logic [31:0] addr;
        logic        exp;
    } vec_t;

    localparam vec_t VECS [13] = '{
        '{C_X|C_M,     32'h0000_1000, 2'd0, 1'b1, 32'h0000_1000, 1'b1}, // R4
        '{C_X|C_M,     32'h0000_1000, 2'd0, 1'b1, 32'h0000_1001, 1'b0}, // R4
        '{C_X|C_M,     32'h8000_1000, 2'd0, 1'b1, 32'h0000_1000, 1'b0}, // R4 top bit
        '{C_L|C_M|C_R, 32'h0000_2003, 2'd1, 1'b1, 32'h0000_2007, 1'b1}, // R5 8-byte
        '{C_L|C_M|C_R, 32'h0000_2003, 2'd1, 1'b1, 32'h0000_2008, 1'b0}, // R5
        '{C_L|C_M|C_R, 32'h0000_2003, 2'd1, 1'b1, 32'h0000_2000, 1'b1}, // R5
        '{C_S|C_M|C_R, 32'hFFFF_FFFF, 2'd2, 1'b1, 32'h1234_5678, 1'b1}, // R5 all ones
        '{C_L|C_M,     32'h0000_3000, 2'd2, 1'b1, 32'h0000_3000, 1'b0}, // R6
        '{C_S|C_U,     32'h0000_3000, 2'd2, 1'b0, 32'h0000_3000, 1'b1}, // R7
        '{C_S|C_M,     32'h0000_3000, 2'd2, 1'b0, 32'h0000_3000, 1'b0}, // R7
        '{C_X|C_U,     32'h0000_4000, 2'd0, 1'b1, 32'h0000_4000, 1'b0}, // R7
        '{C_L|C_M|C_R, 32'h0000_5000, 2'd1, 1'b1, 32'h0000_5001, 1'b1}, // R5 2-byte
        '{C_L|C_M|C_R, 32'h0000_5000, 2'd1, 1'b1, 32'h0000_5002, 1'b0}  // R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    // drive one access at a negedge, sample request before the next edge,
    // then drop it after that edge so hit flags update
    task automatic access(input logic [1:0] kind, input logic pm, input logic [31:0] a,
                          output logic req);
        @(negedge clk);
        priv_m = pm;
        fetch_vld = (kind == 0); fetch_addr = a;
        load_vld  = (kind == 1); load_addr  = a;
        store_vld = (kind == 2); store_addr = a;
        #1 req = bkpt_req;
        @(negedge clk);
        fetch_vld = 0; load_vld = 0; store_vld = 0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic r;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(2'd0, d); check("R1 sel", d, 0);
        rd(2'd1, d); check("R1 ctl", d, 0);
        rd(2'd2, d); check("R1 adr", d, 0);
        rd(2'd3, d); check("R1 gen", d, 0);
        check("R1 req", {31'b0, bkpt_req}, 0);

        // R11 enable register layout
        wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, d); check("R11 gen layout", d, 32'h88);

        // table walk on trigger 0, live enable set
        wr(2'd3, 32'h08);
        wr(2'd0, 0);
        for (int i = 0; i < 13; i++) begin
            wr(2'd1, 0);
            wr(2'd2, VECS[i].cmp);
            wr(2'd1, VECS[i].ctl);
            access(VECS[i].kind, VECS[i].pm, VECS[i].addr, r);
            check($sformatf("R12 vec%0d req", i), {31'b0, r}, {31'b0, VECS[i].exp});
            rd(2'd1, d);
            check($sformatf("R8 vec%0d hit", i), d[20], {31'b0, VECS[i].exp});
        end

        // R8 sticky across idle cycles, cleared by control write
        wr(2'd1, 0); wr(2'd2, 32'h600); wr(2'd1, C_X|C_M);
        access(2'd0, 1, 32'h600, r);
        repeat (3) @(negedge clk);
        rd(2'd1, d); check("R8 sticky", d, C_X|C_M|C_H);
        wr(2'd1, C_X|C_M); rd(2'd1, d); check("R8 cleared", d, C_X|C_M);

        // R7 machine mode blocked while live enable is clear
        wr(2'd3, 0);
        access(2'd0, 1, 32'h600, r); check("R7 mte off", {31'b0, r}, 0);

        // R3 legal bits, write zero disables
        wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); check("R3 legal", d, 32'h0010_00CF);
        wr(2'd3, 32'h08);
        wr(2'd1, 0); rd(2'd1, d); check("R3 zero", d, 0);
        access(2'd0, 1, 32'h600, r); check("R3 disabled", {31'b0, r}, 0);

        // R2 selector clamp and per-trigger data
        wr(2'd0, 7); rd(2'd0, d); check("R2 clamp", d, 3);
        wr(2'd2, 32'hAAAA_0000);
        wr(2'd0, 1); wr(2'd2, 32'h0000_0100); wr(2'd1, C_L|C_M);
        wr(2'd0, 2); wr(2'd2, 32'h0000_0100); wr(2'd1, C_L|C_M);
        wr(2'd0, 3); rd(2'd2, d); check("R2 trig3 adr", d, 32'hAAAA_0000);

        // R9 two triggers hit together
        access(2'd1, 1, 32'h100, r); check("R9 one req", {31'b0, r}, 1);
        wr(2'd0, 1); rd(2'd1, d); check("R9 trig1 hit", d[20], 1);
        wr(2'd0, 2); rd(2'd1, d); check("R9 trig2 hit", d[20], 1);
        wr(2'd0, 3); rd(2'd1, d); check("R9 trig3 idle", d[20], 0);

        // R10 trap / return sequencing, live enable set
        @(negedge clk); trap_enter = 1; @(negedge clk); trap_enter = 0;
        rd(2'd3, d); check("R10 trap", d, 32'h80);
        @(negedge clk); trap_return = 1; @(negedge clk); trap_return = 0;
        rd(2'd3, d); check("R10 return", d, 32'h88);
        wr(2'd3, 32'h08);
        @(negedge clk); trap_enter = 1; trap_return = 1; csr_we = 1; csr_addr = 2'd3;
        csr_wdata = 32'h0;
        @(negedge clk); trap_enter = 0; trap_return = 0; csr_we = 0;
        rd(2'd3, d); check("R10 trap wins", d, 32'h80);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule